// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a free-running 64-bit system time value in scaled fixed-point units. On each enabled edge of its reference clock it adds a programmable increment to the count. The increment is chosen so that a plain right shift turns the count into nanoseconds. Software trims the clock frequency by rewriting the increment while the counter runs. The accumulated count is not disturbed when this happens.

A small register port gives access to the count and the increment. The count can be read as a low word and a high word. Reading the low word captures the high word, so the pair belongs together. Software can also write either word, for example to zero, to restart the count.

A build-time parameter selects the increment layout. The wide layout uses a 31-bit increment. The narrow layout uses a 24-bit increment, with an 8-bit period field above it that paces how often the increment is added. Software normally writes that period field as 1. Typical wide increments are 0x66666666 (nanosecond shift 28) for a 6.4 ns reference period, 0x40000000 (shift 24) for 64 ns, and 0x50000000 (shift 21) for 640 ns. The narrow layout uses the same values shifted right by 7, with shifts reduced by 7.

Top module: `tod_counter`

## Requirements
- R1: On every enabled reference clock edge, the 64-bit count grows by the increment field, zero-extended. In the wide layout every edge is enabled.
- R2: While the increment field is zero, the count keeps its value.
- R3: The register address selects the word: 0 is the count low word, 1 is the count high word, 2 is the increment register. Address 3 maps to nothing: writes to it change nothing, and reads of it return 0. Read data appears on `regRdData` after the clock edge at which `regRdEn` is sampled, and holds until the next read.
- R4: A read of the low word captures the high word at the same edge. A read of the high word returns that captured value, not the live high word.
- R5: A write to a count word loads that word at the next edge and leaves the other word unchanged. No increment is added in that cycle, so the write wins over accumulation.
- R6: Rewriting the increment does not disturb the count. The add at the write edge uses the old increment, and the new increment is used from the following edge on.
- R7: In the wide layout, the increment field is register bits [30:0]. Bit 31 is dropped, and it reads back as 0.
- R8: In the narrow layout, the increment field is bits [23:0] and the period field is bits [31:24]. The increment is added once every `period` edges, and a period of 0 stops accumulation. The pacing restarts when the increment register is written, so the first add comes `period` edges after the write edge.
- R9: A carry out of the low word during accumulation advances the high word by one.
- R10: A synchronous reset clears the count, the increment register, the captured high word and the read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register select |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data |

## Verification
Two functions can fall in the same cycle:
- **Count-word write and accumulation.** The bench provokes this by writing a count word while a non-zero increment is active. It then reads the word back at the very next edge and expects exactly the written value, with no increment added.
- **Low-word capture and carry.** The bench sets the low word a few units below its wrap, so the carry lands between a low read and the high read that follows. It expects the old high word from the captured copy, and the advanced high word on the next low/high pair.

The bench also rewrites the increment in a cycle that adds. It judges the result from the difference between low-word reads taken on either side of that cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int WORD_W = 32;

  // strobes and values the control hands to the datapath each cycle
  typedef struct packed {
    logic              wrLo;
    logic              wrHi;
    logic              rdLo;
    logic              rdHi;
    logic              rdInc;
    logic              rdNone;
    logic              addEn;
    logic [WORD_W-1:0] wrData;
    logic [WORD_W-1:0] incAmount;
    logic [WORD_W-1:0] incView;
  } todStrobes_t;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter bit NARROW       = 1'b0,
  parameter int NARROW_INC_W = 24,
  parameter int WIDE_INC_W   = 31,
  parameter int ADDR_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output todStrobes_t       strobes
);
  localparam int INC_W = NARROW ? NARROW_INC_W : WIDE_INC_W;
  localparam int PER_W = WORD_W - NARROW_INC_W;
  localparam logic [ADDR_W-1:0] ADDR_LO  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_HI  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(2);

  logic [INC_W-1:0]  incField;
  logic [WORD_W-1:0] incView;
  logic              pace;
  logic              wrInc;
  logic              hitAny;

  assign hitAny = (addr == ADDR_LO) || (addr == ADDR_HI) || (addr == ADDR_INC);
  assign wrInc  = wrEn && (addr == ADDR_INC);

  always_ff @(posedge clk) begin
    if (rst)        incField <= '0;
    else if (wrInc) incField <= wrData[INC_W-1:0];
  end

  generate
    if (NARROW) begin : g_narrow
      logic [PER_W-1:0] period;
      logic [PER_W-1:0] paceCnt;

      // add once every `period` edges; period 0 stops accumulation
      assign pace    = (period != '0) && (paceCnt >= period - 1'b1);
      assign incView = {period, incField};

      always_ff @(posedge clk) begin
        if (rst) begin
          period  <= '0;
          paceCnt <= '0;
        end else if (wrInc) begin
          period  <= wrData[WORD_W-1:NARROW_INC_W];
          paceCnt <= '0;
        end else if (period != '0) begin
          paceCnt <= pace ? '0 : paceCnt + 1'b1;
        end
      end

      // period field zero must never let an add through
      assert_period_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |-> !pace);
    end else begin : g_wide
      assign pace    = 1'b1;
      assign incView = {{(WORD_W-INC_W){1'b0}}, incField};
    end
  endgenerate

  always_comb begin
    strobes           = '0;
    strobes.wrLo      = wrEn && (addr == ADDR_LO);
    strobes.wrHi      = wrEn && (addr == ADDR_HI);
    strobes.rdLo      = rdEn && (addr == ADDR_LO);
    strobes.rdHi      = rdEn && (addr == ADDR_HI);
    strobes.rdInc     = rdEn && (addr == ADDR_INC);
    strobes.rdNone    = rdEn && !hitAny;
    strobes.addEn     = pace;
    strobes.wrData    = wrData;
    strobes.incAmount = {{(WORD_W-INC_W){1'b0}}, incField};
    strobes.incView   = incView;
  end

  // a write to the unmapped address leaves the increment alone
  assert_unmapped_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !hitAny) |=> $stable(incField));

  // a written increment is visible from the next edge
  assert_inc_write_R6: assert property (@(posedge clk) disable iff (rst)
    wrInc |=> (incField == $past(wrData[INC_W-1:0])));
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  todStrobes_t       s,
  output logic [WORD_W-1:0] rdData
);
  logic [CNT_W-1:0]  count;
  logic [WORD_W-1:0] snapHi;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      snapHi <= '0;
      rdData <= '0;
    end else begin
      if (s.wrLo)       count[WORD_W-1:0]     <= s.wrData;
      else if (s.wrHi)  count[CNT_W-1:WORD_W] <= s.wrData;
      else if (s.addEn) count <= count + {{(CNT_W-WORD_W){1'b0}}, s.incAmount};

      if (s.rdLo) begin
        rdData <= count[WORD_W-1:0];
        snapHi <= count[CNT_W-1:WORD_W];
      end else if (s.rdHi) begin
        rdData <= snapHi;
      end else if (s.rdInc) begin
        rdData <= s.incView;
      end else if (s.rdNone) begin
        rdData <= '0;
      end
    end
  end

  assert_zero_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (s.addEn && s.incAmount == '0 && !s.wrLo && !s.wrHi) |=> $stable(count));

  assert_word_write_R5: assert property (@(posedge clk) disable iff (rst)
    s.wrLo |=> (count[WORD_W-1:0] == $past(s.wrData)) &&
               (count[CNT_W-1:WORD_W] == $past(count[CNT_W-1:WORD_W])));

  assert_other_word_R5: assert property (@(posedge clk) disable iff (rst)
    s.wrHi |=> (count[CNT_W-1:WORD_W] == $past(s.wrData)) &&
               (count[WORD_W-1:0] == $past(count[WORD_W-1:0])));

  assert_carry_R9: assert property (@(posedge clk) disable iff (rst)
    (!s.wrLo && !s.wrHi && s.addEn &&
     (({1'b0, count[WORD_W-1:0]} + {1'b0, s.incAmount}) > {1'b0, {WORD_W{1'b1}}}))
    |=> (count[CNT_W-1:WORD_W] == $past(count[CNT_W-1:WORD_W]) + 1'b1));

  assert_snapshot_R4: assert property (@(posedge clk) disable iff (rst)
    (s.rdLo ##1 s.rdHi) |=> (rdData == $past(count[CNT_W-1:WORD_W], 2)));

  assert_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> (count == '0 && rdData == '0));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter bit NARROW = 1'b0,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData
);
  todStrobes_t strobes;

  tod_ctrl #(
    .NARROW       (NARROW),
    .NARROW_INC_W (24),
    .WIDE_INC_W   (31),
    .ADDR_W       (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (regWrEn),
    .rdEn    (regRdEn),
    .addr    (regAddr),
    .wrData  (regWrData),
    .strobes (strobes)
  );

  tod_datapath #(
    .CNT_W (2 * WORD_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .s      (strobes),
    .rdData (regRdData)
  );
endmodule

// File: tb/tod_counter_test.sv
`timescale 1ns/1ps
module tod_counter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdW;
  logic [31:0] rdN;
  int          checkCnt = 0;
  int          failCnt = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tod_counter #(.NARROW(1'b0), .ADDR_W(2)) uut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(rdW));

  tod_counter #(.NARROW(1'b1), .ADDR_W(2)) uutNarrow (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(rdN));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] w, output logic [31:0] n);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    w = rdW; n = rdN;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic testReset;
    logic [31:0] w, n;
    rdReg(0, w, n); chk("R10 wide low after reset", w, 0); chk("R10 narrow low after reset", n, 0);
    rdReg(1, w, n); chk("R10 wide high after reset", w, 0); chk("R10 narrow high after reset", n, 0);
    rdReg(2, w, n); chk("R10 wide incr after reset", w, 0); chk("R10 narrow incr after reset", n, 0);
    idle(3);
    rdReg(0, w, n); chk("R2 wide zero incr holds", w, 0); chk("R2 narrow zero incr holds", n, 0);
  endtask

  task automatic testAccumulate;
    logic [31:0] w1, n1, w2, n2;
    wrReg(2, 32'h0100_0005);
    rdReg(2, w1, n1);
    chk("R3 wide incr readback", w1, 32'h0100_0005);
    chk("R8 narrow incr readback", n1, 32'h0100_0005);
    rdReg(0, w1, n1);
    rdReg(0, w2, n2);
    chk("R1 wide step", w2 - w1, 32'h0100_0005);
    chk("R8 narrow step period 1", n2 - n1, 32'h0000_0005);
  endtask

  task automatic testCarrySnapshot;
    logic [31:0] w, n;
    wrReg(0, 32'hFFFF_FFF0);
    wrReg(1, 32'h0000_0007);
    rdReg(0, w, n);
    chk("R5 wide low loaded", w, 32'hFFFF_FFF0);
    chk("R5 narrow low loaded", n, 32'hFFFF_FFF0);
    rdReg(1, w, n);
    chk("R4 wide captured high", w, 32'h0000_0007);
    chk("R4 narrow captured high", n, 32'h0000_0007);
    rdReg(0, w, n);
    chk("R9 wide low after carry", w, 32'h01FF_FFFA);
    chk("R1 narrow low two adds", n, 32'hFFFF_FFFA);
    rdReg(1, w, n);
    chk("R9 wide high after carry", w, 32'h0000_0008);
    chk("R9 narrow high no carry", n, 32'h0000_0007);
  endtask

  task automatic testWriteWins;
    logic [31:0] w, n;
    idle(2);
    wrReg(0, 32'h1234_5678);
    rdReg(0, w, n);
    chk("R5 wide write wins over add", w, 32'h1234_5678);
    chk("R5 narrow write wins over add", n, 32'h1234_5678);
  endtask

  task automatic testTrim;
    logic [31:0] w1, n1, w2, n2, w3, n3;
    rdReg(0, w1, n1);
    wrReg(2, 32'h0100_0100);
    rdReg(0, w2, n2);
    rdReg(0, w3, n3);
    chk("R6 wide old incr in write cycle", w2 - w1, 32'h0200_000A);
    chk("R6 narrow old incr in write cycle", n2 - n1, 32'h0000_000A);
    chk("R6 wide new incr next edge", w3 - w2, 32'h0100_0100);
    chk("R6 narrow new incr next edge", n3 - n2, 32'h0000_0100);
  endtask

  task automatic testPeriod;
    logic [31:0] w1, n1, w2, n2, w3, n3;
    wrReg(2, 32'h0300_0010);
    rdReg(0, w1, n1);
    idle(5);
    rdReg(0, w2, n2);
    rdReg(0, w3, n3);
    chk("R1 wide six edges", w2 - w1, 32'h1200_0060);
    chk("R8 narrow period 3 two adds", n2 - n1, 32'h0000_0020);
    chk("R1 wide adjacent", w3 - w2, 32'h0300_0010);
    chk("R8 narrow no add off period", n3 - n2, 32'h0000_0000);
  endtask

  task automatic testPeriodZeroAndBit31;
    logic [31:0] w1, n1, w2, n2;
    wrReg(2, 32'h0000_0007);
    rdReg(0, w1, n1);
    rdReg(0, w2, n2);
    chk("R1 wide incr 7", w2 - w1, 32'h0000_0007);
    chk("R8 narrow period 0 holds", n2 - n1, 32'h0000_0000);
    wrReg(2, 32'h8000_0007);
    rdReg(2, w1, n1);
    chk("R7 wide bit 31 dropped", w1, 32'h0000_0007);
    chk("R8 narrow period readback", n1, 32'h8000_0007);
  endtask

  task automatic testNominal;
    logic [31:0] w1, n1, w2, n2;
    wrReg(2, 32'h66CC_CCCC);
    rdReg(0, w1, n1);
    rdReg(0, w2, n2);
    chk("R7 wide field 31 bits", w2 - w1, 32'h66CC_CCCC);
    wrReg(2, 32'h01CC_CCCC);
    rdReg(0, w1, n1);
    rdReg(0, w2, n2);
    chk("R8 narrow 24-bit field", n2 - n1, 32'h00CC_CCCC);
    chk("R1 wide 0x01CCCCCC step", w2 - w1, 32'h01CC_CCCC);
  endtask

  task automatic testUnmapped;
    logic [31:0] w, n;
    wrReg(3, 32'hDEAD_BEEF);
    rdReg(2, w, n);
    chk("R3 wide unmapped write ignored", w, 32'h01CC_CCCC);
    chk("R3 narrow unmapped write ignored", n, 32'h01CC_CCCC);
    rdReg(3, w, n);
    chk("R3 wide unmapped reads 0", w, 0);
    chk("R3 narrow unmapped reads 0", n, 0);
  endtask

  task automatic testRestart;
    logic [31:0] w, n;
    wrReg(2, 32'h0);
    wrReg(0, 32'h0);
    wrReg(1, 32'h0);
    rdReg(0, w, n); chk("R5 wide restart low", w, 0); chk("R5 narrow restart low", n, 0);
    rdReg(1, w, n); chk("R5 wide restart high", w, 0); chk("R5 narrow restart high", n, 0);
    idle(2);
    rdReg(0, w, n); chk("R2 wide held at zero", w, 0); chk("R2 narrow held at zero", n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testAccumulate();
    testCarrySnapshot();
    testWriteWins();
    testTrim();
    testPeriod();
    testPeriodZeroAndBit31();
    testNominal();
    testUnmapped();
    testRestart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule